// File: doc/BRIEF.md
# LIN Response Byte-Length Counter

This block keeps the data lengths that software programs for a LIN response and tracks how far the response has progressed. Software writes a transmit length and a receive length, each four bits wide, and then issues a command that starts either a transmit or a receive response. When the command is accepted, the length field for that direction is clamped to at most eight bytes. The field for the other direction is cleared and becomes a live count of the data bytes that have completed.

The frame engine pulses `byte_done` for every byte that completes, `resp_end` when the response finishes cleanly and `resp_err` when it fails. The block raises `csum_next` whenever the count of completed data bytes has reached the programmed length, so the next byte on the wire is the checksum. A length of zero therefore makes the first byte the checksum. On an error the count freezes, so software can read how many bytes got through before the failure.

The controller has four states, of type `resp_state_e`:
- ST_IDLE is left for ST_TX_RUN on an accepted transmit command.
- ST_IDLE is left for ST_RX_RUN on an accepted receive command.
- ST_TX_RUN and ST_RX_RUN return to ST_IDLE on `resp_end`.
- ST_TX_RUN and ST_RX_RUN go to ST_HALT on `resp_err`.
- ST_HALT behaves like ST_IDLE: it accepts writes and commands, and leaves for a run state on a command.

Top module: `lin_resp_len`

## Requirements
- R1: After reset both length fields read 0, `busy` is 0 and `csum_next` is 0.
- R2: When not busy, a write (`wr_en`=1 with `cmd_valid`=0) loads `wr_tx_len` and `wr_rx_len` unmodified into the two fields, which are readable on the following cycle.
- R3: A command with `cmd_is_tx`=1 (transmit) accepted while not busy sets the transmit field to min(value, 8), clears the receive field to 0 and sets `busy`.
- R4: A command with `cmd_is_tx`=0 (receive) accepted while not busy sets the receive field to min(value, 8), clears the transmit field to 0 and sets `busy`.
- R5: While busy, each `byte_done` pulse that arrives while the progress count is below the programmed length adds one to the progress field. In a transmit response the progress field is the receive field; in a receive response it is the transmit field.
- R6: `csum_next` is 1 exactly when the block is busy and the progress count equals the programmed length. With a length of 0 it is 1 from the first busy cycle.
- R7: A `byte_done` that arrives while `csum_next` is 1 (the checksum byte) leaves both fields unchanged.
- R8: `resp_end` while busy returns the block to idle, and both fields keep their values.
- R9: `resp_err` while busy clears `busy` and freezes the progress count. A `byte_done` arriving in the same cycle or later does not change it.
- R10: While busy, writes and new commands are ignored, and both fields keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Software write of both length fields |
| wr_tx_len | input | 4 | Transmit length value to write |
| wr_rx_len | input | 4 | Receive length value to write |
| cmd_valid | input | 1 | Start-response command strobe |
| cmd_is_tx | input | 1 | 1 = transmit response, 0 = receive response |
| byte_done | input | 1 | A response byte completed successfully |
| resp_end | input | 1 | Response finished |
| resp_err | input | 1 | Response aborted by an error |
| tx_len_o | output | 4 | Transmit length, or progress during a receive response |
| rx_len_o | output | 4 | Receive length, or progress during a transmit response |
| csum_next | output | 1 | The next byte is the checksum |
| busy | output | 1 | A response is in progress |

## Verification
Every field update and every change to `busy` appears exactly one clock after the strobe that causes it. `csum_next` is decoded from registered state only, so it is valid in that same cycle. The bench drives each strobe for a single cycle starting at a falling edge and samples at the next falling edge, one rising edge later, where all results are due. It sweeps every 4-bit length in both directions, walks the progress count byte by byte up to the checksum, and checks the frozen count after an error.

// File: rtl/lin_len_pkg.sv
package lin_len_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_TX_RUN = 2'd1,
        ST_RX_RUN = 2'd2,
        ST_HALT   = 2'd3
    } resp_state_e;
endpackage

// File: rtl/lin_len_fsm.sv
module lin_len_fsm
    import lin_len_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_is_tx,
    input  logic        resp_end,
    input  logic        resp_err,
    output resp_state_e state_o,
    output logic        busy_o,
    output logic        cmd_take_o,
    output logic        tx_run_o,
    output logic        rx_run_o
);
    resp_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE, ST_HALT: begin
                if (cmd_valid) st_d = cmd_is_tx ? ST_TX_RUN : ST_RX_RUN;
            end
            ST_TX_RUN, ST_RX_RUN: begin
                if (resp_err)      st_d = ST_HALT;
                else if (resp_end) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        busy_o     = 1'b0;
        tx_run_o   = 1'b0;
        rx_run_o   = 1'b0;
        cmd_take_o = 1'b0;
        unique case (st_q)
            ST_IDLE, ST_HALT: cmd_take_o = cmd_valid;
            ST_TX_RUN: begin busy_o = 1'b1; tx_run_o = 1'b1; end
            ST_RX_RUN: begin busy_o = 1'b1; rx_run_o = 1'b1; end
            default: ;
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/lin_len_field.sv
module lin_len_field #(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_we,
    input  logic [LEN_W-1:0] sw_val,
    input  logic             cmd_load,
    input  logic             cmd_owns,
    input  logic             count_en,
    output logic [LEN_W-1:0] value_o
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    logic [LEN_W-1:0] val_q;
    logic [LEN_W-1:0] clamped;

    assign clamped = (val_q > CAP) ? CAP : val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (cmd_load) begin
            // the commanded direction keeps its clamped length; the other becomes a counter
            val_q <= cmd_owns ? clamped : '0;
        end else if (count_en) begin
            val_q <= val_q + 1'b1;
        end else if (sw_we) begin
            val_q <= sw_val;
        end
    end

    assign value_o = val_q;
endmodule

// File: rtl/lin_resp_len.sv
module lin_resp_len
    import lin_len_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LEN_W-1:0] wr_tx_len,
    input  logic [LEN_W-1:0] wr_rx_len,
    input  logic             cmd_valid,
    input  logic             cmd_is_tx,
    input  logic             byte_done,
    input  logic             resp_end,
    input  logic             resp_err,
    output logic [LEN_W-1:0] tx_len_o,
    output logic [LEN_W-1:0] rx_len_o,
    output logic             csum_next,
    output logic             busy
);
    localparam int NFIELD = 2; // index 0 = transmit, 1 = receive

    resp_state_e st_q;
    logic        cmd_take, tx_run, rx_run, advance, sw_we;
    logic [NFIELD-1:0][LEN_W-1:0] fld, wr_val;
    logic [NFIELD-1:0]            owns, cnt;
    logic [LEN_W-1:0]             len_sel, prog_sel;

    lin_len_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_is_tx  (cmd_is_tx),
        .resp_end   (resp_end),
        .resp_err   (resp_err),
        .state_o    (st_q),
        .busy_o     (busy),
        .cmd_take_o (cmd_take),
        .tx_run_o   (tx_run),
        .rx_run_o   (rx_run)
    );

    assign wr_val[0] = wr_tx_len;
    assign wr_val[1] = wr_rx_len;
    assign owns[0]   = cmd_is_tx;
    assign owns[1]   = ~cmd_is_tx;
    assign sw_we     = wr_en & ~busy & ~cmd_take;

    assign len_sel   = tx_run ? fld[0] : fld[1];
    assign prog_sel  = tx_run ? fld[1] : fld[0];
    assign csum_next = busy & (prog_sel == len_sel);
    assign advance   = byte_done & busy & ~resp_end & ~resp_err & ~csum_next;

    // a transmit response counts in the receive field and vice versa
    assign cnt[0] = advance & rx_run;
    assign cnt[1] = advance & tx_run;

    for (genvar g = 0; g < NFIELD; g++) begin : g_fld
        lin_len_field #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_field (
            .clk      (clk),
            .rst_n    (rst_n),
            .sw_we    (sw_we),
            .sw_val   (wr_val[g]),
            .cmd_load (cmd_take),
            .cmd_owns (owns[g]),
            .count_en (cnt[g]),
            .value_o  (fld[g])
        );
    end

    assign tx_len_o = fld[0];
    assign rx_len_o = fld[1];
endmodule

// File: rtl/lin_resp_len_chk.sv
module lin_resp_len_chk
    import lin_len_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             cmd_valid,
    input  logic             cmd_is_tx,
    input  logic             byte_done,
    input  logic             resp_end,
    input  logic             resp_err,
    input  logic [LEN_W-1:0] tx_len_o,
    input  logic [LEN_W-1:0] rx_len_o,
    input  logic             csum_next,
    input  logic             busy,
    input  resp_state_e      st
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(MAX_LEN);

    a_r3_tx_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && cmd_is_tx) |=> (busy && tx_len_o <= CAP && rx_len_o == '0));

    a_r4_rx_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_valid && !cmd_is_tx) |=> (busy && rx_len_o <= CAP && tx_len_o == '0));

    a_r6_idle_no_csum: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !csum_next);

    a_r7_csum_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && csum_next && byte_done && !resp_end && !resp_err)
        |=> ($stable(tx_len_o) && $stable(rx_len_o)));

    a_r8_end_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && resp_end && !resp_err) |=> (!busy && $stable(tx_len_o) && $stable(rx_len_o)));

    a_r9_halt_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_HALT && !wr_en && !cmd_valid) |=> ($stable(tx_len_o) && $stable(rx_len_o)));

    a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !byte_done && !resp_end && !resp_err)
        |=> ($stable(tx_len_o) && $stable(rx_len_o) && busy));
endmodule

bind lin_resp_len lin_resp_len_chk #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .cmd_valid (cmd_valid),
    .cmd_is_tx (cmd_is_tx),
    .byte_done (byte_done),
    .resp_end  (resp_end),
    .resp_err  (resp_err),
    .tx_len_o  (tx_len_o),
    .rx_len_o  (rx_len_o),
    .csum_next (csum_next),
    .busy      (busy),
    .st        (st_q)
);

// File: tb/lin_resp_len_bench.sv
module lin_resp_len_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0, cmd_valid = 1'b0, cmd_is_tx = 1'b0;
    logic       byte_done = 1'b0, resp_end = 1'b0, resp_err = 1'b0;
    logic [3:0] wr_tx_len = '0, wr_rx_len = '0;
    logic [3:0] tx_len_o, rx_len_o;
    logic       csum_next, busy;
    int         n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    lin_resp_len u_lin_resp_len (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_tx_len(wr_tx_len),
        .wr_rx_len(wr_rx_len), .cmd_valid(cmd_valid), .cmd_is_tx(cmd_is_tx),
        .byte_done(byte_done), .resp_end(resp_end), .resp_err(resp_err),
        .tx_len_o(tx_len_o), .rx_len_o(rx_len_o), .csum_next(csum_next), .busy(busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs are set at a falling edge; one rising edge later, at the next falling edge, they are cleared and results are sampled
    task automatic tick();
        @(negedge clk);
        wr_en = 0; cmd_valid = 0; byte_done = 0; resp_end = 0; resp_err = 0;
    endtask

    task automatic write(input int t, input int r);
        wr_en = 1; wr_tx_len = 4'(t); wr_rx_len = 4'(r); tick();
    endtask

    task automatic cmd(input bit tx);
        cmd_valid = 1; cmd_is_tx = tx; tick();
    endtask

    task automatic run_dir(input bit tx, input int len);
        int eff, lenv, prog;
        eff = (len > 8) ? 8 : len;
        if (tx) write(len, 9); else write(9, len);
        chk("R2 write tx", tx_len_o, tx ? len : 9);
        chk("R2 write rx", rx_len_o, tx ? 9 : len);
        cmd(tx);
        lenv = tx ? tx_len_o : rx_len_o;
        prog = tx ? rx_len_o : tx_len_o;
        chk(tx ? "R3 clamp" : "R4 clamp", lenv, eff);
        chk(tx ? "R3 clear" : "R4 clear", prog, 0);
        chk("R6 csum start", csum_next, eff == 0);
        for (int i = 1; i <= eff; i++) begin
            byte_done = 1; tick();
            chk("R5 count", tx ? rx_len_o : tx_len_o, i);
            chk("R6 csum", csum_next, i == eff);
        end
        byte_done = 1; tick();
        chk("R7 csum byte", tx ? rx_len_o : tx_len_o, eff);
        resp_end = 1; tick();
        chk("R8 idle", busy, 0);
        chk("R8 keep", tx ? tx_len_o : rx_len_o, eff);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        chk("R1 tx", tx_len_o, 0); chk("R1 rx", rx_len_o, 0);
        chk("R1 busy", busy, 0);   chk("R1 csum", csum_next, 0);
        rst_n = 1;
        @(negedge clk);
        for (int l = 0; l < 16; l++) begin
            run_dir(1'b1, l);
            run_dir(1'b0, l);
        end
        // R9: error after two bytes of a five-byte transmit
        write(5, 0); cmd(1'b1);
        byte_done = 1; tick(); byte_done = 1; tick();
        byte_done = 1; resp_err = 1; tick();
        chk("R9 busy", busy, 0);
        chk("R9 frozen", rx_len_o, 2);
        byte_done = 1; tick();
        chk("R9 late byte", rx_len_o, 2);
        chk("R9 csum", csum_next, 0);
        write(3, 4);
        chk("R2 write in halt", rx_len_o, 4);
        // R10: writes and commands while busy are ignored
        cmd(1'b0);
        write(7, 7);
        chk("R10 wr tx", tx_len_o, 0);
        chk("R10 wr rx", rx_len_o, 4);
        cmd(1'b1);
        chk("R10 cmd busy", busy, 1);
        chk("R10 cmd rx", rx_len_o, 4);
        byte_done = 1; tick();
        chk("R5 rx count", tx_len_o, 1);
        resp_end = 1; tick();
        chk("R8 end", busy, 0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule